// File: doc/BRIEF.md
# Saturating Sixteen-Bit ALU

This block is the combinational arithmetic and logic unit of a small register-register processor core. A 4-bit operation select picks one of fourteen functions: signed add and subtract, each in a clamping form and a wrapping form, increment, decrement, four shifts and four bitwise functions. Two 16-bit operands go in. A 16-bit result comes out with two flags: one for signed overflow in the wrapping forms and one for a clamp in the saturating forms.

The shift amount comes from the low four bits of the second operand. The upper bits of that operand are ignored for shifts. Increment and decrement ignore the second operand entirely. The two unused select codes give a result of zero with both flags low, so the output is always defined. Inside the block, a control decoder turns the select into a small struct of strobes. A datapath, built from an adder/subtractor, a shifter and a bitwise unit, acts on that struct.

Top module: `aluTop`

## Requirements
- R1: Select 0000 adds the operands as two's-complement values. If the true sum is above 0x7FFF the result is 0x7FFF; if it is below 0x8000 (as a signed value) the result is 0x8000. In both of those cases saturatedFlag is 1. The overflow flag is always 0 for this select.
- R2: Select 0001 adds the operands and keeps the low 16 bits. overflowFlag is 1 exactly when the signed sum does not fit in 16 bits. saturatedFlag is 0.
- R3: Select 0010 computes operandA minus operandB, clamped to 0x7FFF or 0x8000 on signed overflow. saturatedFlag is 1 exactly when a clamp happened. overflowFlag is 0.
- R4: Select 0011 computes operandA minus operandB, keeps the low 16 bits and sets overflowFlag on signed overflow. saturatedFlag is 0.
- R5: Select 1000 gives operandA+1 and select 1011 gives operandA-1, both wrapping. overflowFlag is 1 only for 0x7FFF+1 and 0x8000-1. operandB has no effect.
- R6: Select 0100 is a logical right shift, 0101 a logical left shift and 0110 an arithmetic (sign-filling) right shift of operandA, by operandB[3:0]. Bits 15..4 of operandB have no effect. Both flags are 0.
- R7: Select 0111 is a left shift like 0101. overflowFlag is 1 when bit 15 of the result differs from bit 15 of operandA.
- R8: Selects 1100, 1101, 1110 and 1111 give the bitwise XOR, OR, AND and NAND of the operands. Both flags are 0.
- R9: Selects 1001 and 1010 give result 0x0000 with both flags 0.
- R10: overflowFlag and saturatedFlag are never both 1. When saturatedFlag is 1, the result is 0x7FFF or 0x8000, and its sign bit equals bit 15 of operandA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation select |
| operandA | input | 16 | First operand; the value that is shifted, incremented or decremented |
| operandB | input | 16 | Second operand; bits 3..0 give the shift amount |
| result | output | 16 | Function result |
| overflowFlag | output | 1 | Signed overflow in a wrapping add/sub, inc/dec, or a sign change in the arithmetic left shift |
| saturatedFlag | output | 1 | Result was clamped by a saturating add or subtract |

## Verification
Signed overflow detection and clamping happen in the same evaluation: the saturating selects must detect the overflow, replace the sum with a limit and raise only the saturated flag. The bench drives operand pairs that overflow in both directions, such as 0x7FFF plus 1 and 0x8000 minus 1. It applies each pair under both the saturating and the wrapping select, and expects a limit value with saturatedFlag in one case and the wrapped sum with overflowFlag in the other. The bench also checks that the two flags never rise together.

// File: rtl/aluPkg.sv
package aluPkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_SAT  = 4'h0,
    OP_ADD_WRAP = 4'h1,
    OP_SUB_SAT  = 4'h2,
    OP_SUB_WRAP = 4'h3,
    OP_LSR      = 4'h4,
    OP_LSL      = 4'h5,
    OP_ASR      = 4'h6,
    OP_ASL      = 4'h7,
    OP_INC      = 4'h8,
    OP_RSV9     = 4'h9,
    OP_RSVA     = 4'hA,
    OP_DEC      = 4'hB,
    OP_XOR      = 4'hC,
    OP_OR       = 4'hD,
    OP_AND      = 4'hE,
    OP_NAND     = 4'hF
  } aluOpE;

  typedef enum logic [1:0] {
    SRC_ZERO,
    SRC_ARITH,
    SRC_SHIFT,
    SRC_LOGIC
  } resSrcE;

  typedef enum logic [1:0] {
    LG_XOR,
    LG_OR,
    LG_AND,
    LG_NAND
  } logicFnE;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    resSrcE  resSrc;
    logic    subtract;
    logic    useOne;
    logic    clamp;
    logic    shiftLeft;
    logic    shiftArith;
    logic    checkSign;
    logicFnE logicFn;
  } aluCtrlS;

endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluCtrlS         ctrl
);

  aluOpE op;
  assign op = aluOpE'(opSel);

  always_comb begin
    ctrl = '{resSrc: SRC_ZERO, subtract: 1'b0, useOne: 1'b0, clamp: 1'b0,
             shiftLeft: 1'b0, shiftArith: 1'b0, checkSign: 1'b0, logicFn: LG_XOR};
    case (op)
      OP_ADD_SAT: begin
        ctrl.resSrc = SRC_ARITH;
        ctrl.clamp  = 1'b1;
      end
      OP_ADD_WRAP: ctrl.resSrc = SRC_ARITH;
      OP_SUB_SAT: begin
        ctrl.resSrc   = SRC_ARITH;
        ctrl.subtract = 1'b1;
        ctrl.clamp    = 1'b1;
      end
      OP_SUB_WRAP: begin
        ctrl.resSrc   = SRC_ARITH;
        ctrl.subtract = 1'b1;
      end
      OP_LSR: ctrl.resSrc = SRC_SHIFT;
      OP_LSL: begin
        ctrl.resSrc    = SRC_SHIFT;
        ctrl.shiftLeft = 1'b1;
      end
      OP_ASR: begin
        ctrl.resSrc     = SRC_SHIFT;
        ctrl.shiftArith = 1'b1;
      end
      OP_ASL: begin
        ctrl.resSrc    = SRC_SHIFT;
        ctrl.shiftLeft = 1'b1;
        ctrl.checkSign = 1'b1;
      end
      OP_INC: begin
        ctrl.resSrc = SRC_ARITH;
        ctrl.useOne = 1'b1;
      end
      OP_DEC: begin
        ctrl.resSrc   = SRC_ARITH;
        ctrl.useOne   = 1'b1;
        ctrl.subtract = 1'b1;
      end
      OP_XOR: begin
        ctrl.resSrc  = SRC_LOGIC;
        ctrl.logicFn = LG_XOR;
      end
      OP_OR: begin
        ctrl.resSrc  = SRC_LOGIC;
        ctrl.logicFn = LG_OR;
      end
      OP_AND: begin
        ctrl.resSrc  = SRC_LOGIC;
        ctrl.logicFn = LG_AND;
      end
      OP_NAND: begin
        ctrl.resSrc  = SRC_LOGIC;
        ctrl.logicFn = LG_NAND;
      end
      default: ctrl.resSrc = SRC_ZERO;
    endcase
  end

endmodule

// File: rtl/aluAddSub.sv
module aluAddSub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             subtract,
  input  logic             useOne,
  input  logic             clamp,
  output logic [WIDTH-1:0] sum,
  output logic             ovf,
  output logic             sat
);

  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] POS_MAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_MIN = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] bSel, bEff, rawSum, carryIn;
  logic             rawOvf;

  assign bSel    = useOne ? ONE : b;
  assign bEff    = subtract ? ~bSel : bSel;
  assign carryIn = {{(WIDTH-1){1'b0}}, subtract};
  assign rawSum  = a + bEff + carryIn;
  // Operands of equal sign giving a result of the other sign
  assign rawOvf  = (a[MSB] == bEff[MSB]) && (rawSum[MSB] != a[MSB]);

  always_comb begin
    if (clamp && rawOvf) begin
      sum = a[MSB] ? NEG_MIN : POS_MAX;
      sat = 1'b1;
      ovf = 1'b0;
    end else begin
      sum = rawSum;
      sat = 1'b0;
      ovf = rawOvf && !clamp;
    end
  end

endmodule

// File: rtl/aluShifter.sv
module aluShifter #(
  parameter int WIDTH = 16,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [SH_W-1:0]  shamt,
  input  logic             shiftLeft,
  input  logic             shiftArith,
  input  logic             checkSign,
  output logic [WIDTH-1:0] shOut,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] leftVal, rightLog, rightArith;

  assign leftVal    = a << shamt;
  assign rightLog   = a >> shamt;
  assign rightArith = $unsigned($signed(a) >>> shamt);

  always_comb begin
    if (shiftLeft)       shOut = leftVal;
    else if (shiftArith) shOut = rightArith;
    else                 shOut = rightLog;
  end

  assign ovf = checkSign && (leftVal[MSB] != a[MSB]);

endmodule

// File: rtl/aluLogic.sv
module aluLogic
  import aluPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logicFnE          fn,
  output logic [WIDTH-1:0] lgOut
);

  always_comb begin
    case (fn)
      LG_XOR:  lgOut = a ^ b;
      LG_OR:   lgOut = a | b;
      LG_AND:  lgOut = a & b;
      default: lgOut = ~(a & b);
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 16,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  aluCtrlS          ctrl,
  input  logic [WIDTH-1:0] operandA,
  input  logic [WIDTH-1:0] operandB,
  output logic [WIDTH-1:0] result,
  output logic             overflowFlag,
  output logic             saturatedFlag
);

  logic [WIDTH-1:0] arithOut, shiftOut, logicOut;
  logic             arithOvf, arithSat, shiftOvf;

  aluAddSub #(.WIDTH(WIDTH)) addSubUnit (
    .a(operandA), .b(operandB), .subtract(ctrl.subtract), .useOne(ctrl.useOne),
    .clamp(ctrl.clamp), .sum(arithOut), .ovf(arithOvf), .sat(arithSat)
  );

  aluShifter #(.WIDTH(WIDTH)) shiftUnit (
    .a(operandA), .shamt(operandB[SH_W-1:0]), .shiftLeft(ctrl.shiftLeft),
    .shiftArith(ctrl.shiftArith), .checkSign(ctrl.checkSign),
    .shOut(shiftOut), .ovf(shiftOvf)
  );

  aluLogic #(.WIDTH(WIDTH)) logicUnit (
    .a(operandA), .b(operandB), .fn(ctrl.logicFn), .lgOut(logicOut)
  );

  always_comb begin
    result        = '0;
    overflowFlag  = 1'b0;
    saturatedFlag = 1'b0;
    case (ctrl.resSrc)
      SRC_ARITH: begin
        result        = arithOut;
        overflowFlag  = arithOvf;
        saturatedFlag = arithSat;
      end
      SRC_SHIFT: begin
        result       = shiftOut;
        overflowFlag = shiftOvf;
      end
      SRC_LOGIC: result = logicOut;
      default:   result = '0;
    endcase
  end

endmodule

// File: rtl/aluTop.sv
module aluTop
  import aluPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [OP_W-1:0]  opSel,
  input  logic [WIDTH-1:0] operandA,
  input  logic [WIDTH-1:0] operandB,
  output logic [WIDTH-1:0] result,
  output logic             overflowFlag,
  output logic             saturatedFlag
);

  aluCtrlS ctrl;

  aluControl decoder (
    .opSel(opSel), .ctrl(ctrl)
  );

  aluDatapath #(.WIDTH(WIDTH)) datapath (
    .ctrl(ctrl), .operandA(operandA), .operandB(operandB),
    .result(result), .overflowFlag(overflowFlag), .saturatedFlag(saturatedFlag)
  );

endmodule

// File: rtl/aluChecker.sv
module aluChecker #(
  parameter int WIDTH = 16
) (
  input logic [3:0]       opSel,
  input logic [WIDTH-1:0] operandA,
  input logic [WIDTH-1:0] result,
  input logic             overflowFlag,
  input logic             saturatedFlag
);

  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] POS_MAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_MIN = {1'b1, {(WIDTH-1){1'b0}}};

  always_comb begin
    // R10
    flags_exclusive_chk: assert (!(overflowFlag && saturatedFlag))
      else $error("both flags set");
    // R10
    sat_limit_chk: assert (!saturatedFlag || result == POS_MAX || result == NEG_MIN)
      else $error("saturated result not a limit");
    // R10
    sat_sign_chk: assert (!saturatedFlag || result[MSB] == operandA[MSB])
      else $error("saturated sign mismatch");
    // R9
    unused_zero_chk: assert (!(opSel == 4'h9 || opSel == 4'hA) ||
                             (result == '0 && !overflowFlag && !saturatedFlag))
      else $error("unused select not zero");
    // R1
    sat_no_ovf_chk: assert (!(opSel == 4'h0 || opSel == 4'h2) || !overflowFlag)
      else $error("overflow on saturating select");
    // R8
    logic_flag_chk: assert (!(opSel[3:2] == 2'b11) || (!overflowFlag && !saturatedFlag))
      else $error("flag on bitwise select");
    // R5
    inc_ovf_chk: assert (!(opSel == 4'h8 && overflowFlag) || operandA == POS_MAX)
      else $error("increment overflow at wrong value");
  end

endmodule

bind aluTop aluChecker #(.WIDTH(WIDTH)) aluCheck (
  .opSel(opSel), .operandA(operandA), .result(result),
  .overflowFlag(overflowFlag), .saturatedFlag(saturatedFlag)
);

// File: tb/aluTop_test.sv
`timescale 1ns/1ps
module aluTop_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opSel = 4'h0;
  logic [15:0] operandA = 16'h0, operandB = 16'h0;
  logic [15:0] result;
  logic        overflowFlag, saturatedFlag;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  aluTop uut (
    .opSel(opSel), .operandA(operandA), .operandB(operandB),
    .result(result), .overflowFlag(overflowFlag), .saturatedFlag(saturatedFlag)
  );

  // Drive on the rising edge, sample on the falling edge
  task automatic applyCheck(input string tag, input logic [3:0] op,
                            input logic [15:0] a, input logic [15:0] b,
                            input logic [15:0] expRes, input logic expOvf,
                            input logic expSat);
    @(posedge clk);
    opSel = op; operandA = a; operandB = b;
    @(negedge clk);
    checks++;
    if (result !== expRes || overflowFlag !== expOvf || saturatedFlag !== expSat) begin
      errors++;
      $display("FAIL %s op=%h a=%h b=%h: got res=%h ovf=%b sat=%b, expected res=%h ovf=%b sat=%b",
               tag, op, a, b, result, overflowFlag, saturatedFlag, expRes, expOvf, expSat);
    end
  endtask

  task automatic testReset();
    applyCheck("reset R1", 4'h0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic testAddSat();
    applyCheck("R1 pos clamp", 4'h0, 16'h7FFF, 16'h0001, 16'h7FFF, 1'b0, 1'b1);
    applyCheck("R1 neg clamp", 4'h0, 16'h8000, 16'hFFFF, 16'h8000, 1'b0, 1'b1);
    applyCheck("R1 plain",     4'h0, 16'h0003, 16'h0004, 16'h0007, 1'b0, 1'b0);
  endtask

  task automatic testAddWrap();
    applyCheck("R2 pos wrap", 4'h1, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 1'b0);
    applyCheck("R2 neg wrap", 4'h1, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b0);
    applyCheck("R2 plain",    4'h1, 16'h1234, 16'h1111, 16'h2345, 1'b0, 1'b0);
  endtask

  task automatic testSubSat();
    applyCheck("R3 neg clamp", 4'h2, 16'h8000, 16'h0001, 16'h8000, 1'b0, 1'b1);
    applyCheck("R3 pos clamp", 4'h2, 16'h7FFF, 16'hFFFF, 16'h7FFF, 1'b0, 1'b1);
    applyCheck("R3 plain",     4'h2, 16'h0005, 16'h0007, 16'hFFFE, 1'b0, 1'b0);
  endtask

  task automatic testSubWrap();
    applyCheck("R4 neg wrap", 4'h3, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 1'b0);
    applyCheck("R4 pos wrap", 4'h3, 16'h0000, 16'h8000, 16'h8000, 1'b1, 1'b0);
    applyCheck("R4 plain",    4'h3, 16'h0010, 16'h0003, 16'h000D, 1'b0, 1'b0);
  endtask

  task automatic testIncDec();
    applyCheck("R5 inc ovf",   4'h8, 16'h7FFF, 16'h0000, 16'h8000, 1'b1, 1'b0);
    applyCheck("R5 inc wrap",  4'h8, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 1'b0);
    applyCheck("R5 inc b ign", 4'h8, 16'h0041, 16'h1234, 16'h0042, 1'b0, 1'b0);
    applyCheck("R5 dec ovf",   4'hB, 16'h8000, 16'h0000, 16'h7FFF, 1'b1, 1'b0);
    applyCheck("R5 dec wrap",  4'hB, 16'h0000, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
  endtask

  task automatic testShifts();
    applyCheck("R6 lsr",        4'h4, 16'h8001, 16'h0004, 16'h0800, 1'b0, 1'b0);
    applyCheck("R6 lsr hi ign", 4'h4, 16'h8001, 16'hFFF4, 16'h0800, 1'b0, 1'b0);
    applyCheck("R6 lsl",        4'h5, 16'h8001, 16'h0001, 16'h0002, 1'b0, 1'b0);
    applyCheck("R6 asr fill",   4'h6, 16'h8000, 16'h000F, 16'hFFFF, 1'b0, 1'b0);
    applyCheck("R6 asr pos",    4'h6, 16'h4000, 16'h0002, 16'h1000, 1'b0, 1'b0);
    applyCheck("R6 shift zero", 4'h6, 16'hA5A5, 16'h0010, 16'hA5A5, 1'b0, 1'b0);
  endtask

  task automatic testAsl();
    applyCheck("R7 sign flip", 4'h7, 16'h4000, 16'h0001, 16'h8000, 1'b1, 1'b0);
    applyCheck("R7 sign kept", 4'h7, 16'hC000, 16'h0001, 16'h8000, 1'b0, 1'b0);
    applyCheck("R7 small",     4'h7, 16'h0001, 16'h0003, 16'h0008, 1'b0, 1'b0);
  endtask

  task automatic testLogic();
    applyCheck("R8 xor",  4'hC, 16'hF0F0, 16'hFF00, 16'h0FF0, 1'b0, 1'b0);
    applyCheck("R8 or",   4'hD, 16'hF0F0, 16'hFF00, 16'hFFF0, 1'b0, 1'b0);
    applyCheck("R8 and",  4'hE, 16'hF0F0, 16'hFF00, 16'hF000, 1'b0, 1'b0);
    applyCheck("R8 nand", 4'hF, 16'hF0F0, 16'hFF00, 16'h0FFF, 1'b0, 1'b0);
  endtask

  task automatic testUnused();
    applyCheck("R9 code 9", 4'h9, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 1'b0);
    applyCheck("R9 code A", 4'hA, 16'h7FFF, 16'h0001, 16'h0000, 1'b0, 1'b0);
  endtask

  // R10: flags never both set over a sweep of overflow-prone pairs
  task automatic testFlagExclusive();
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 4; k++) begin
        @(posedge clk);
        opSel = 4'(i); operandA = 16'h7FFF + 16'(k); operandB = 16'h7FFF + 16'(i * k);
        @(negedge clk);
        checks++;
        if (overflowFlag && saturatedFlag) begin
          errors++;
          $display("FAIL R10 op=%h: got ovf=%b sat=%b, expected not both set",
                   opSel, overflowFlag, saturatedFlag);
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testReset();
    testAddSat();
    testAddWrap();
    testSubSat();
    testSubWrap();
    testIncDec();
    testShifts();
    testAsl();
    testLogic();
    testUnused();
    testFlagExclusive();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule